// File: doc/BRIEF.md
# Two-Level SIMD Reduction Compute Unit

This block is the arithmetic heart of a dynamic-programming processing element. A single instruction word carries three opcodes and six operands. One first-level ALU takes four operands, a second first-level ALU takes two, and a second-level ALU combines the two first-level results. This lets a typical cell-update pattern finish in one issue, for example "best of four candidate scores, then add a penalty". A multiplier sits beside the tree rather than in it. When the multiply-select bit is set, the multiplier's product replaces the tree result, so the tree's combinational depth does not grow.

Every ALU and the multiplier can work on one 32-bit word or on four independent packed 8-bit lanes. The lane mode lets four low-precision scoring tables advance together. The result is registered once and marked valid in the cycle after issue. A halt opcode in any slot stops the unit: it sets a stop flag that stays set until reset, and the unit ignores all later issues.

Top module: `cu_simd_tree`

## Requirements
- R1: After reset, `result_o` is 0, `res_valid_o` is 0 and `halted_o` is 0.
- R2: An accepted issue produces `res_valid_o`=1 and the new `result_o` on the next clock edge. A cycle without issue leaves `res_valid_o`=0 on the next edge and keeps `result_o` unchanged.
- R3: The opcodes are 4 bits wide: 0 NOP, 1 ADD, 2 SUB, 3 CARRY, 4 BORROW, 5 MAX, 6 MIN, 7 MAX4, 8 MIN4, 9 SHL16, 10 SHR16, 11 COPY, 12 MATCH, 13 SELGT, 14 SELEQ, 15 HALT. `result_o` is computed in three steps:
  - ALU A applies `op_a_i` to the operands (x,y,z,w) = (a0,a1,a2,a3).
  - ALU B applies `op_b_i` to (b0,b1,b0,b1).
  - ALU C applies `op_c_i` to (A,B,A,B).
- R4: All arithmetic is unsigned and wraps modulo the lane width:
  - ADD gives x+y.
  - SUB gives x-y.
  - CARRY gives the carry-out of x+y (0 or 1).
  - BORROW gives 1 when x<y and 0 otherwise.
- R5: MAX and MIN return the larger or smaller of x and y. MAX4 and MIN4 return the largest or smallest of all four inputs x, y, z and w.
- R6: SHL16 and SHR16 shift the whole 32-bit x left or right by 16 with zero fill, in both modes.
- R7: COPY returns x. NOP returns 0.
- R8: MATCH returns the match parameter (default 5) when x==y and the mismatch parameter (default 0xFFFFFFFC) otherwise. In lane mode each lane uses the low 8 bits of these parameters.
- R9: SELGT returns z when x>y and w otherwise. SELEQ returns z when x==y and w otherwise.
- R10: With `simd_i`=1, every operation except the shifts works on four separate 8-bit lanes (bits 8k+7..8k). No carry, borrow or comparison crosses a lane boundary.
- R11: With `mul_sel_i`=1, the result is the low 32 bits of a0*a1. In lane mode it is instead the low 8 bits of each lane product. The tree result is discarded.
- R12: A HALT in any opcode slot of an accepted issue sets `halted_o`, which stays 1 until reset. That issue and every later issue leave `result_o` unchanged and `res_valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction present this cycle |
| simd_i | input | 1 | 1 = four 8-bit lanes, 0 = one 32-bit word |
| mul_sel_i | input | 1 | 1 = result comes from the multiplier |
| op_a_i | input | 4 | Opcode of the four-input first-level ALU |
| op_b_i | input | 4 | Opcode of the two-input first-level ALU |
| op_c_i | input | 4 | Opcode of the second-level ALU |
| opd_a0_i | input | 32 | Operand x of ALU A, also multiplicand |
| opd_a1_i | input | 32 | Operand y of ALU A, also multiplier |
| opd_a2_i | input | 32 | Operand z of ALU A |
| opd_a3_i | input | 32 | Operand w of ALU A |
| opd_b0_i | input | 32 | Operand x of ALU B |
| opd_b1_i | input | 32 | Operand y of ALU B |
| result_o | output | 32 | Registered result |
| res_valid_o | output | 1 | Result updated on the last edge |
| halted_o | output | 1 | Sticky stop flag |

## Verification
The bench sweeps every non-halt pairing of first-level and second-level opcodes, in both word and lane mode. It uses three operand sets:
- The first set mixes lanes that overflow with lanes that do not, and has sign-like high bits. It shows whether carries, borrows and unsigned comparisons stop at lane boundaries.
- The second set has equal operand pairs. It separates the equal and unequal paths of MATCH and SELEQ.
- The third set sits at 0/1 and all-ones edges. It tells wrap-around apart from saturation and exposes which shift direction is used.

Directed issues then cover both multiplier widths, a cycle without issue, and a halt placed in the middle opcode slot followed by an ignored issue.

// File: rtl/cu_pkg.sv
// Package: shared opcode type and default widths of the reduction compute unit.
// Assumes: opcode field is 4 bits; encodings are fixed by the instruction format.
package cu_pkg;

    localparam int CU_OP_W = 4;

    typedef enum logic [CU_OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_ADD    = 4'd1,
        OP_SUB    = 4'd2,
        OP_CARRY  = 4'd3,
        OP_BORROW = 4'd4,
        OP_MAX    = 4'd5,
        OP_MIN    = 4'd6,
        OP_MAX4   = 4'd7,
        OP_MIN4   = 4'd8,
        OP_SHL    = 4'd9,
        OP_SHR    = 4'd10,
        OP_COPY   = 4'd11,
        OP_MATCH  = 4'd12,
        OP_SELGT  = 4'd13,
        OP_SELEQ  = 4'd14,
        OP_HALT   = 4'd15
    } cu_op_e;

endpackage

// File: rtl/cu_lane.sv
// Module: cu_lane
// One unsigned lane of an ALU, of width W. Handles every lane-local operation.
// Assumes: shifts, NOP and HALT are resolved by the caller (this lane returns 0).
module cu_lane
    import cu_pkg::*;
#(
    parameter int W = 32
) (
    input  cu_op_e         op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic [W-1:0]   z,
    input  logic [W-1:0]   w,
    input  logic [W-1:0]   match_v,
    input  logic [W-1:0]   mism_v,
    output logic [W-1:0]   r
);

    logic [W:0]   sum;
    logic [W-1:0] hi_xy, hi_zw, lo_xy, lo_zw;

    // Pairwise reduction tree for the four-input operations.
    always_comb begin
        sum   = {1'b0, x} + {1'b0, y};
        hi_xy = (x > y) ? x : y;
        hi_zw = (z > w) ? z : w;
        lo_xy = (x < y) ? x : y;
        lo_zw = (z < w) ? z : w;
    end

    // Operation select for this lane.
    always_comb begin
        case (op)
            OP_ADD:    r = sum[W-1:0];
            OP_SUB:    r = x - y;
            OP_CARRY:  r = {{(W-1){1'b0}}, sum[W]};
            OP_BORROW: r = {{(W-1){1'b0}}, (x < y)};
            OP_MAX:    r = hi_xy;
            OP_MIN:    r = lo_xy;
            OP_MAX4:   r = (hi_xy > hi_zw) ? hi_xy : hi_zw;
            OP_MIN4:   r = (lo_xy < lo_zw) ? lo_xy : lo_zw;
            OP_COPY:   r = x;
            OP_MATCH:  r = (x == y) ? match_v : mism_v;
            OP_SELGT:  r = (x > y) ? z : w;
            OP_SELEQ:  r = (x == y) ? z : w;
            default:   r = '0;
        endcase
    end

endmodule

// File: rtl/cu_alu.sv
// Module: cu_alu
// One ALU of the tree. It has a full-width lane and LANE_W-wide SIMD lanes.
// simd picks which lane set drives the result; the 16-bit shifts always act on
// the whole word.
// Assumes: DATA_W is a multiple of LANE_W; the shift distance is DATA_W/2.
module cu_alu
    import cu_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          LANE_W    = 8,
    parameter logic [31:0] MATCH_VAL = 32'd5,
    parameter logic [31:0] MISM_VAL  = 32'hFFFF_FFFC
) (
    input  cu_op_e              op,
    input  logic                simd,
    input  logic [DATA_W-1:0]   x,
    input  logic [DATA_W-1:0]   y,
    input  logic [DATA_W-1:0]   z,
    input  logic [DATA_W-1:0]   w,
    output logic [DATA_W-1:0]   r
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int SH    = DATA_W / 2;

    logic [DATA_W-1:0] full_r;
    logic [DATA_W-1:0] simd_r;

    cu_lane #(.W(DATA_W)) u_full (
        .op(op), .x(x), .y(y), .z(z), .w(w),
        .match_v(MATCH_VAL[DATA_W-1:0]), .mism_v(MISM_VAL[DATA_W-1:0]),
        .r(full_r)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cu_lane #(.W(LANE_W)) u_lane (
            .op(op),
            .x(x[l*LANE_W +: LANE_W]), .y(y[l*LANE_W +: LANE_W]),
            .z(z[l*LANE_W +: LANE_W]), .w(w[l*LANE_W +: LANE_W]),
            .match_v(MATCH_VAL[LANE_W-1:0]), .mism_v(MISM_VAL[LANE_W-1:0]),
            .r(simd_r[l*LANE_W +: LANE_W])
        );
    end

    // Output select: whole-word shifts, otherwise the lane set chosen by simd.
    always_comb begin
        case (op)
            OP_SHL:  r = x << SH;
            OP_SHR:  r = x >> SH;
            default: r = simd ? simd_r : full_r;
        endcase
    end

endmodule

// File: rtl/cu_mul.sv
// Module: cu_mul
// Multiplier kept off the ALU tree. It gives the low DATA_W bits of the product,
// or in SIMD mode the low LANE_W bits of each lane product.
// Assumes: unsigned operands; purely combinational.
module cu_mul #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                simd,
    input  logic [DATA_W-1:0]   x,
    input  logic [DATA_W-1:0]   y,
    output logic [DATA_W-1:0]   p
);

    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] full_p;
    logic [DATA_W-1:0] simd_p;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [2*LANE_W-1:0] prod;
        // Per-lane product, truncated to the lane width.
        always_comb begin
            prod = x[l*LANE_W +: LANE_W] * y[l*LANE_W +: LANE_W];
            simd_p[l*LANE_W +: LANE_W] = prod[LANE_W-1:0];
        end
    end

    // Full-width product and mode select.
    always_comb begin
        full_p = x * y;
        p      = simd ? simd_p : full_p;
    end

endmodule

// File: rtl/cu_simd_tree.sv
// Module: cu_simd_tree (top)
// Two-level ALU reduction compute unit. ALU A (four operands) and ALU B (two
// operands) feed ALU C; a side multiplier can replace the tree result. There is
// one register stage; a HALT opcode in any slot latches a sticky stop flag.
// Assumes: synchronous active-low reset; two-input ALUs see (x,y,x,y).
module cu_simd_tree
    import cu_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          LANE_W    = 8,
    parameter logic [31:0] MATCH_VAL = 32'd5,
    parameter logic [31:0] MISM_VAL  = 32'hFFFF_FFFC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic                simd_i,
    input  logic                mul_sel_i,
    input  logic [3:0]          op_a_i,
    input  logic [3:0]          op_b_i,
    input  logic [3:0]          op_c_i,
    input  logic [DATA_W-1:0]   opd_a0_i,
    input  logic [DATA_W-1:0]   opd_a1_i,
    input  logic [DATA_W-1:0]   opd_a2_i,
    input  logic [DATA_W-1:0]   opd_a3_i,
    input  logic [DATA_W-1:0]   opd_b0_i,
    input  logic [DATA_W-1:0]   opd_b1_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                res_valid_o,
    output logic                halted_o
);

    cu_op_e            op_a, op_b, op_c;
    logic [DATA_W-1:0] res_a, res_b, res_c, prod;
    logic [DATA_W-1:0] next_res;
    logic              halt_hit;

    // Decode the opcode fields and detect a halt in any slot.
    always_comb begin
        op_a     = cu_op_e'(op_a_i);
        op_b     = cu_op_e'(op_b_i);
        op_c     = cu_op_e'(op_c_i);
        halt_hit = (op_a == OP_HALT) || (op_b == OP_HALT) || (op_c == OP_HALT);
    end

    cu_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W), .MATCH_VAL(MATCH_VAL), .MISM_VAL(MISM_VAL))
    u_alu_a (
        .op(op_a), .simd(simd_i),
        .x(opd_a0_i), .y(opd_a1_i), .z(opd_a2_i), .w(opd_a3_i),
        .r(res_a)
    );

    cu_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W), .MATCH_VAL(MATCH_VAL), .MISM_VAL(MISM_VAL))
    u_alu_b (
        .op(op_b), .simd(simd_i),
        .x(opd_b0_i), .y(opd_b1_i), .z(opd_b0_i), .w(opd_b1_i),
        .r(res_b)
    );

    cu_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W), .MATCH_VAL(MATCH_VAL), .MISM_VAL(MISM_VAL))
    u_alu_c (
        .op(op_c), .simd(simd_i),
        .x(res_a), .y(res_b), .z(res_a), .w(res_b),
        .r(res_c)
    );

    cu_mul #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mul (
        .simd(simd_i), .x(opd_a0_i), .y(opd_a1_i), .p(prod)
    );

    // Pick the tree or the multiplier as the candidate result.
    always_comb begin
        next_res = mul_sel_i ? prod : res_c;
    end

    // Result register, valid flag and sticky halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o    <= '0;
            res_valid_o <= 1'b0;
            halted_o    <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            if (issue_i && !halted_o) begin
                if (halt_hit) begin
                    halted_o <= 1'b1;
                end else begin
                    result_o    <= next_res;
                    res_valid_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cu_simd_tree_chk.sv
// Module: cu_simd_tree_chk
// Protocol and function checks for cu_simd_tree, attached through bind.
// Assumes: HALT encodes as 15, COPY as 11, SHR16 as 10 (matches cu_pkg).
module cu_simd_tree_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic              mul_sel_i,
    input logic [3:0]        op_a_i,
    input logic [3:0]        op_b_i,
    input logic [3:0]        op_c_i,
    input logic [DATA_W-1:0] opd_a0_i,
    input logic [DATA_W-1:0] result_o,
    input logic              res_valid_o,
    input logic              halted_o
);

    logic go;
    // An issue that will be accepted and is not a halt.
    always_comb begin
        go = issue_i && !halted_o && (op_a_i != 4'd15) && (op_b_i != 4'd15) && (op_c_i != 4'd15);
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> res_valid_o);                                              // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!res_valid_o && $stable(result_o)));                // R2
    AST_COPY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !mul_sel_i && op_a_i == 4'd11 && op_c_i == 4'd11)
        |=> (result_o == $past(opd_a0_i)));                               // R7
    AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !mul_sel_i && op_c_i == 4'd10)
        |=> (result_o[DATA_W-1:DATA_W/2] == '0));                         // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);                                           // R12
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !res_valid_o);                                       // R12
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> $stable(result_o));                                  // R12

endmodule

bind cu_simd_tree cu_simd_tree_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .mul_sel_i(mul_sel_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i), .opd_a0_i(opd_a0_i),
    .result_o(result_o), .res_valid_o(res_valid_o), .halted_o(halted_o)
);

// File: tb/cu_simd_tree_tb.sv
`timescale 1ns/1ps
module cu_simd_tree_tb;

    localparam logic [31:0] MV  = 32'd5;
    localparam logic [31:0] MMV = 32'hFFFF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0, simd_i = 1'b0, mul_sel_i = 1'b0;
    logic [3:0]  op_a_i = '0, op_b_i = '0, op_c_i = '0;
    logic [31:0] a0 = '0, a1 = '0, a2 = '0, a3 = '0, b0 = '0, b1 = '0;
    logic [31:0] result_o;
    logic        res_valid_o, halted_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cu_simd_tree u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .simd_i(simd_i),
        .mul_sel_i(mul_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i),
        .opd_a0_i(a0), .opd_a1_i(a1), .opd_a2_i(a2), .opd_a3_i(a3),
        .opd_b0_i(b0), .opd_b1_i(b1),
        .result_o(result_o), .res_valid_o(res_valid_o), .halted_o(halted_o)
    );

    // Arithmetic model of one lane of width wd.
    function automatic logic [31:0] m_lane(int op, logic [63:0] x, logic [63:0] y,
                                           logic [63:0] z, logic [63:0] u, int wd);
        logic [63:0] m, t1, t2, r;
        m = (64'd1 << wd) - 64'd1;
        x &= m; y &= m; z &= m; u &= m;
        case (op)
            1:  r = (x + y) & m;
            2:  r = (x - y) & m;
            3:  r = ((x + y) >> wd) & 64'd1;
            4:  r = (x < y) ? 64'd1 : 64'd0;
            5:  r = (x >= y) ? x : y;
            6:  r = (x <= y) ? x : y;
            7:  begin t1 = (x >= y) ? x : y; t2 = (z >= u) ? z : u; r = (t1 >= t2) ? t1 : t2; end
            8:  begin t1 = (x <= y) ? x : y; t2 = (z <= u) ? z : u; r = (t1 <= t2) ? t1 : t2; end
            11: r = x;
            12: r = (x == y) ? ({32'd0, MV} & m) : ({32'd0, MMV} & m);
            13: r = (x > y) ? z : u;
            14: r = (x == y) ? z : u;
            default: r = 64'd0;
        endcase
        return r[31:0];
    endfunction

    // Model of one ALU over a whole word.
    function automatic logic [31:0] m_alu(int op, logic [31:0] x, logic [31:0] y,
                                          logic [31:0] z, logic [31:0] u, bit sm);
        logic [31:0] r;
        if (op == 9)       r = {x[15:0], 16'd0};
        else if (op == 10) r = {16'd0, x[31:16]};
        else if (!sm)      r = m_lane(op, x, y, z, u, 32);
        else begin
            for (int l = 0; l < 4; l++) begin
                logic [31:0] t;
                t = m_lane(op, x[8*l +: 8], y[8*l +: 8], z[8*l +: 8], u[8*l +: 8], 8);
                r[8*l +: 8] = t[7:0];
            end
        end
        return r;
    endfunction

    // Multiplier model.
    function automatic logic [31:0] m_mul(logic [31:0] x, logic [31:0] y, bit sm);
        logic [31:0] r;
        logic [63:0] f;
        if (!sm) begin f = {32'd0, x} * {32'd0, y}; r = f[31:0]; end
        else begin
            for (int l = 0; l < 4; l++) begin
                logic [15:0] p;
                p = {8'd0, x[8*l +: 8]} * {8'd0, y[8*l +: 8]};
                r[8*l +: 8] = p[7:0];
            end
        end
        return r;
    endfunction

    // Requirement tag for the operation that decides the final result.
    function automatic string tag_of(int op, bit sm);
        string s;
        case (op)
            0, 11:       s = "R7";
            1, 2, 3, 4:  s = "R4";
            5, 6, 7, 8:  s = "R5";
            9, 10:       s = "R6";
            12:          s = "R8";
            default:     s = "R9";
        endcase
        if (sm) s = {s, "/R10"};
        return {s, "/R3"};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one instruction, then check valid and result after the capturing edge.
    task automatic run(int oa, int ob, int oc, bit sm, bit ml,
                       logic [31:0] x0, logic [31:0] x1, logic [31:0] x2,
                       logic [31:0] x3, logic [31:0] y0, logic [31:0] y1, string req);
        logic [31:0] ra, rb, exp;
        ra  = m_alu(oa, x0, x1, x2, x3, sm);
        rb  = m_alu(ob, y0, y1, y0, y1, sm);
        exp = ml ? m_mul(x0, x1, sm) : m_alu(oc, ra, rb, ra, rb, sm);
        op_a_i = 4'(oa); op_b_i = 4'(ob); op_c_i = 4'(oc);
        simd_i = sm; mul_sel_i = ml;
        a0 = x0; a1 = x1; a2 = x2; a3 = x3; b0 = y0; b1 = y1;
        issue_i = 1'b1;
        @(negedge clk);
        check({req, " valid (R2)"}, {31'd0, res_valid_o}, 32'd1);
        check(req, result_o, exp);
    endtask

    task automatic pick_vec(int v, output logic [31:0] x0, output logic [31:0] x1,
                            output logic [31:0] x2, output logic [31:0] x3,
                            output logic [31:0] y0, output logic [31:0] y1);
        case (v)
            0: begin x0 = 32'h8001_FF10; x1 = 32'h8001_0120; x2 = 32'h1234_5678;
                     x3 = 32'h9ABC_DEF0; y0 = 32'h7F7F_8080; y1 = 32'h0180_7F80; end
            1: begin x0 = 32'hFFFF_FFFF; x1 = 32'hFFFF_FFFF; x2 = 32'h0;
                     x3 = 32'h5A5A_5A5A; y0 = 32'h1111_1111; y1 = 32'h1111_1111; end
            default: begin x0 = 32'h0000_0001; x1 = 32'hFFFF_FFFF; x2 = 32'h00FF_00FF;
                     x3 = 32'hFF00_FF00; y0 = 32'h0000_0100; y1 = 32'h0000_00FF; end
        endcase
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] x0, x1, x2, x3, y0, y1, held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", result_o, 32'd0);
        check("R1 valid", {31'd0, res_valid_o}, 32'd0);
        check("R1 halted", {31'd0, halted_o}, 32'd0);
        rst_n = 1'b1;

        // Sweep of opcode pairings, both modes, three operand sets.
        for (int v = 0; v < 3; v++) begin
            pick_vec(v, x0, x1, x2, x3, y0, y1);
            for (int sm = 0; sm < 2; sm++)
                for (int oa = 0; oa < 15; oa++)
                    for (int oc = 0; oc < 15; oc++)
                        run(oa, (oa + oc) % 15, oc, sm[0], 1'b0,
                            x0, x1, x2, x3, y0, y1, tag_of(oc, sm[0]));
        end

        // R11: multiplier in word and lane mode; tree opcodes ignored.
        run(1, 1, 1, 1'b0, 1'b1, 32'h0001_0003, 32'h0002_0005, 0, 0, 7, 9, "R11 word");
        run(5, 2, 6, 1'b1, 1'b1, 32'h10FF_0307, 32'h1002_0509, 0, 0, 1, 1, "R11 lanes");
        run(7, 1, 1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, "R11 wrap");

        // R10: lane carry must not ripple.
        run(11, 0, 1, 1'b1, 1'b0, 32'h00FF_FFFF, 0, 0, 0, 0, 0, "R10 no ripple");
        run(11, 11, 1, 1'b1, 1'b0, 32'h01FF_80FF, 0, 0, 0, 32'h0101_8001, 0, "R10 lane add");

        // R2: idle cycle keeps result, drops valid.
        held = result_o;
        issue_i = 1'b0;
        @(negedge clk);
        check("R2 idle valid", {31'd0, res_valid_o}, 32'd0);
        check("R2 idle hold", result_o, held);

        // R12: halt in the middle slot; later issues ignored.
        held = result_o;
        op_a_i = 4'd1; op_b_i = 4'd15; op_c_i = 4'd1; mul_sel_i = 1'b0;
        issue_i = 1'b1;
        @(negedge clk);
        check("R12 halted", {31'd0, halted_o}, 32'd1);
        check("R12 no valid", {31'd0, res_valid_o}, 32'd0);
        check("R12 hold on halt", result_o, held);
        op_b_i = 4'd1; a0 = 32'h1234; a1 = 32'h1;
        repeat (3) @(negedge clk);
        check("R12 sticky", {31'd0, halted_o}, 32'd1);
        check("R12 ignored valid", {31'd0, res_valid_o}, 32'd0);
        check("R12 ignored result", result_o, held);
        issue_i = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule